// File: doc/BRIEF.md
# Two-Bank Byte-Lane Memory Port

This block sits between a byte-addressed memory space and a 16-bit data bus. The storage is split into two 8-bit banks. The upper bank serves bus bits 15..8 and the lower bank serves bus bits 7..0.

Each request carries four things:

- a byte address;
- an active-low upper-lane strobe;
- a read and/or write request;
- write data.

Both banks share the same word index, which is the byte address with bit 0 removed. Each bank is switched on separately:

- the upper bank is enabled by the strobe;
- the lower bank is enabled by address bit 0 being low.

In a single bus cycle the block therefore moves either an aligned 16-bit word, an even byte on the low lane, or an odd byte on the high lane. The one combination that would need two bus cycles is rejected with an error flag.

Writes take effect at the clock edge where the request is presented. Reads return registered data one clock later, and any lane whose bank was not enabled reads back as zero. The address width is a parameter: a width of 20 gives the full 1 MB space. The default is kept small so the internal bank arrays stay modest.

Top module: `banked_byte_port`

## Requirements
- R1: `word_addr` equals byte address bits [ADDR_W-1:1] and indexes both banks; consecutive aligned word accesses whose byte addresses differ by 2 present word indices that differ by 1.
- R2: With `ube_n`=0 and `addr[0]`=0, a request is a word access: `hi_en`=1 and `lo_en`=1, and the access moves all 16 bits.
- R3: With `ube_n`=0 and `addr[0]`=1, a request is an odd-byte access: only `hi_en`=1, and the data travels on bus bits 15..8.
- R4: With `ube_n`=1 and `addr[0]`=0, a request is an even-byte access: only `lo_en`=1, and the data travels on bus bits 7..0.
- R5: With `ube_n`=1 and `addr[0]`=1, a request raises `err`=1 with both enables 0, changes no stored byte, and produces no `rd_valid`.
- R6: A write commits on the clock edge of the request and updates only the enabled bank(s); the other lane's stored byte at that index is unchanged.
- R7: A legal read gives `rd_valid`=1 one clock after the request, with the stored bytes on the enabled lanes and zero on any disabled lane.
- R8: When `rd_req` and `wr_req` are both high, the request is a write only: no `rd_valid` follows, and `rd_data` is 0.
- R9: During and after reset, `rd_valid`=0 and `rd_data`=0. With no request, `hi_en`, `lo_en` and `err` are 0, and `rd_valid`/`rd_data` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| ube_n | input | 1 | Active-low upper-lane strobe |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| wr_data | input | 16 | Write data; lanes 15..8 and 7..0 |
| word_addr | output | ADDR_W-1 | Word index shared by both banks |
| hi_en | output | 1 | Upper bank enabled this cycle |
| lo_en | output | 1 | Lower bank enabled this cycle |
| err | output | 1 | Request needs two bus cycles and is rejected |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The lane decode is combinational, so a wrong enable or error decision is visible on `hi_en`, `lo_en` and `err` in the same cycle as the request. A bank byte that is corrupted, or written through a lane that should have been disabled, stays hidden until that index is read back. The bench therefore keeps a byte-exact model of both banks and follows every write with random word and byte reads, so a bad stored byte shows up on `rd_data` one clock after the read that touches it. Lane isolation is shown by the zeros the disabled half must carry on every byte read.

// File: rtl/banked_byte_port.sv
module banked_byte_port #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ube_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [15:0]       wr_data,
  output logic [ADDR_W-2:0] word_addr,
  output logic              hi_en,
  output logic              lo_en,
  output logic              err,
  output logic [15:0]       rd_data,
  output logic              rd_valid
);
  localparam int WA_W  = ADDR_W - 1;
  localparam int DEPTH = 1 << WA_W;

  logic [7:0] hi_mem [DEPTH];
  logic [7:0] lo_mem [DEPTH];

  logic active, legal, rd_go;

  assign active    = rd_req | wr_req;
  assign legal     = ~(ube_n & addr[0]);
  assign word_addr = addr[ADDR_W-1:1];
  assign hi_en     = active & legal & ~ube_n;
  assign lo_en     = active & legal & ~addr[0];
  assign err       = active & ~legal;
  assign rd_go     = rd_req & ~wr_req & legal;

  always_ff @(posedge clk) begin
    if (wr_req && hi_en) hi_mem[word_addr] <= wr_data[15:8];
    if (wr_req && lo_en) lo_mem[word_addr] <= wr_data[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      rd_data  <= rd_go ? {hi_en ? hi_mem[word_addr] : 8'h00,
                           lo_en ? lo_mem[word_addr] : 8'h00} : 16'h0000;
    end
  end

  // lane-preservation tracking for assertions
  logic [WA_W-1:0] chk_wa;
  logic [7:0]      chk_hi, chk_lo;
  logic            chk_lo_only, chk_hi_only, chk_none;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_lo_only <= 1'b0;
      chk_hi_only <= 1'b0;
      chk_none    <= 1'b0;
      chk_wa      <= '0;
      chk_hi      <= '0;
      chk_lo      <= '0;
    end else begin
      chk_wa      <= word_addr;
      chk_hi      <= hi_mem[word_addr];
      chk_lo      <= lo_mem[word_addr];
      chk_lo_only <= wr_req & lo_en & ~hi_en;
      chk_hi_only <= wr_req & hi_en & ~lo_en;
      chk_none    <= wr_req & err;
    end
  end

  assert_err_no_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!hi_en && !lo_en));
  assert_err_no_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !rd_valid);
  assert_err_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_none |-> (hi_mem[chk_wa] == chk_hi && lo_mem[chk_wa] == chk_lo));
  assert_hi_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_lo_only |-> hi_mem[chk_wa] == chk_hi);
  assert_lo_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hi_only |-> lo_mem[chk_wa] == chk_lo);
  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req && !err) |=> rd_valid);
  assert_even_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req && ube_n && !err) |=> rd_data[15:8] == 8'h00);
  assert_odd_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req && addr[0] && !err) |=> rd_data[7:0] == 8'h00);
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !rd_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_valid && rd_data == 16'h0000));
endmodule

// File: tb/sim_banked_byte_port.sv
module sim_banked_byte_port;
  localparam int AW = 9;
  localparam int DEPTH = 1 << (AW - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ube_n = 1'b1, rd_req = 1'b0, wr_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic [AW-2:0] word_addr;
  logic hi_en, lo_en, err, rd_valid;
  logic [15:0] rd_data;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] m_hi [DEPTH];
  logic [7:0] m_lo [DEPTH];

  banked_byte_port #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ube_n(ube_n), .rd_req(rd_req),
    .wr_req(wr_req), .wr_data(wr_data), .word_addr(word_addr), .hi_en(hi_en),
    .lo_en(lo_en), .err(err), .rd_data(rd_data), .rd_valid(rd_valid));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_hi(input logic [AW-1:0] a, input logic hb, input logic any);
    return any && !(hb && a[0]) && !hb;
  endfunction
  function automatic logic exp_lo(input logic [AW-1:0] a, input logic hb, input logic any);
    return any && !(hb && a[0]) && !a[0];
  endfunction

  task automatic op(input string tag, input logic [AW-1:0] a, input logic hb,
                    input logic r, input logic w, input logic [15:0] d);
    logic any, legal, eh, el, ev;
    logic [AW-2:0] wa;
    logic [15:0] er;
    any = r | w;
    legal = !(hb && a[0]);
    eh = exp_hi(a, hb, any);
    el = exp_lo(a, hb, any);
    wa = a[AW-1:1];
    addr = a; ube_n = hb; rd_req = r; wr_req = w; wr_data = d;
    #1;
    check({tag, " hi_en"}, 32'(hi_en), 32'(eh));
    check({tag, " lo_en"}, 32'(lo_en), 32'(el));
    check({tag, " err"}, 32'(err), 32'(any && !legal));
    if (any) check({tag, " word_addr"}, 32'(word_addr), 32'(wa));
    ev = r && !w && legal;
    er = {eh ? m_hi[wa] : 8'h00, el ? m_lo[wa] : 8'h00};
    if (!ev) er = 16'h0000;
    if (w) begin
      if (eh) m_hi[wa] = d[15:8];
      if (el) m_lo[wa] = d[7:0];
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " rd_valid"}, 32'(rd_valid), 32'(ev));
    check({tag, " rd_data"}, 32'(rd_data), 32'(er));
    rd_req = 1'b0; wr_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset rd_valid", 32'(rd_valid), 0);
    check("R9 reset rd_data", 32'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle hi_en", 32'(hi_en), 0);
    check("R9 idle lo_en", 32'(lo_en), 0);
    check("R9 idle err", 32'(err), 0);

    for (int i = 0; i < DEPTH; i++)
      op("R2 init", AW'(2 * i), 1'b0, 1'b0, 1'b1, 16'($urandom));

    op("R1 step", 9'h010, 1'b0, 1'b1, 1'b0, 16'h0);
    check("R1 word index", 32'(word_addr), 32'h08);
    op("R1 step", 9'h012, 1'b0, 1'b1, 1'b0, 16'h0);
    check("R1 word index next", 32'(word_addr), 32'h09);

    op("R2 word wr", 9'h020, 1'b0, 1'b0, 1'b1, 16'hA55A);
    op("R2 word rd", 9'h020, 1'b0, 1'b1, 1'b0, 16'h0);
    op("R3 odd wr", 9'h021, 1'b0, 1'b0, 1'b1, 16'h3CFF);
    op("R6 after odd wr", 9'h020, 1'b0, 1'b1, 1'b0, 16'h0);
    op("R4 even wr", 9'h020, 1'b1, 1'b0, 1'b1, 16'hFFC3);
    op("R6 after even wr", 9'h020, 1'b0, 1'b1, 1'b0, 16'h0);
    op("R3 odd rd", 9'h021, 1'b0, 1'b1, 1'b0, 16'h0);
    op("R4 even rd", 9'h020, 1'b1, 1'b1, 1'b0, 16'h0);
    op("R5 bad wr", 9'h021, 1'b1, 1'b0, 1'b1, 16'h1111);
    op("R5 bad rd", 9'h021, 1'b1, 1'b1, 1'b0, 16'h0);
    op("R5 unchanged", 9'h020, 1'b0, 1'b1, 1'b0, 16'h0);
    op("R8 rd+wr", 9'h030, 1'b0, 1'b1, 1'b1, 16'h7E81);
    op("R8 readback", 9'h030, 1'b0, 1'b1, 1'b0, 16'h0);
    op("R9 idle", 9'h000, 1'b0, 1'b0, 1'b0, 16'h0);
    op("R2 top word", 9'h1FE, 1'b0, 1'b0, 1'b1, 16'hBEEF);
    op("R3 top odd", 9'h1FF, 1'b0, 1'b1, 1'b0, 16'h0);
    op("R4 top even", 9'h1FE, 1'b1, 1'b1, 1'b0, 16'h0);

    for (int i = 0; i < 600; i++) begin
      logic [2:0] k;
      k = 3'($urandom);
      op("R7 random", AW'($urandom), 1'($urandom), k[0] | k[1], k[2] & k[1], 16'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule